// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port reached over a simple single-cycle register bus. Software sets a per-line direction, writes output levels into a data register and reads input levels back from the same register. The address of every data access carries a lane mask in bits [9:2]. A store therefore touches only the selected lines, and a load returns only the selected lines, with no read-modify-write sequence in software.

Each line's pin value comes from one of four per-line modes, picked every cycle: DRIVE (output line, carries its data bit), PULL_HI (input line with pull-up, reads 1), PULL_LO (input line with only a pull-down, reads 0) and FLOAT (input line with no pull, keeps the value it last had). External levels pass through a two-flop synchronizer and then load the data bits of input lines. Two variants are chosen by parameter: in one the pull masks are fixed parameters, and in the other they are registers that software can write. A bus request falls into one of six access classes: IDLE, DATA, DIR, PULL_UP, PULL_DN, HOLE. Every request goes back to IDLE on the next cycle unless a new request is present.

Top module: `gpio_mask_port`

## Requirements
- R1: During and after reset the data and direction registers are 0, so every line is an input. Each pin then shows its pull-up bit: 0x00 in the writable-pull variant and the parameter mask (0xFF by default) in the fixed variant.
- R2: Any offset from 0x000 to 0x3FF reads the data register ANDed with address bits [9:2]. Read data appears on the cycle after the request, with bits [31:8] zero.
- R3: Offset 0x400 is the direction register, where bit n = 1 makes line n an output. A write keeps only wdata[7:0], and a read returns that value zero-extended.
- R4: A write to the data window changes only the data bits that are set both in address bits [9:2] and in the direction register. Every other data bit keeps its value.
- R5: The data bit of an input line takes the external level three clock edges after the level changes: two synchronizer stages, then the data register. The data bit of an output line ignores its external input.
- R6: The pin of an output line equals its data bit, one cycle after the data or direction register changes.
- R7: An input line whose pull-up bit is set shows 1. An input line with only its pull-down bit set shows 0. If both bits are set, which is not a legal configuration, the pull-up wins.
- R8: An input line with neither pull bit set is floating. Its pin keeps the last value it had, whatever the external input does.
- R9: In the writable-pull variant the pull-up mask is at offset 0x510 and the pull-down mask at 0x514. Both keep wdata[7:0] and reset to 0. In the fixed variant the pull masks are parameters, these offsets read 0, and writes to them have no effect.
- R10: Any other offset, including 0x401 to 0x403, reads 0. A write to such an offset changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Request valid for this cycle |
| bus_write_i | input | 1 | 1 = write request, 0 = read request |
| bus_addr_i | input | 12 | Byte offset of the request |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after a read request |
| pin_i | input | 8 | External line levels (asynchronous) |
| pin_o | output | 8 | Resolved level of each line |

## Verification
Several internal faults reach the ports quickly. A data bit that takes a write outside its lane and direction mask shows up on pin_o one cycle later if the line is an output, and on the next masked read if it is not. A wrong mode choice in the pin resolver shows on pin_o in the cycle after the configuration write. A floating line that loses its held value shows as a pin change that follows pin_i and no register write.

Some faults surface only on a delayed read. A wrong synchronizer depth moves the cycle in which a masked read first returns a new external level. A direction or pull register that takes a write aimed at a hole offset is visible at once when that register is read back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Byte offsets that the bus decoder recognises.
    localparam int unsigned DATA_WINDOW_END = 'h400;
    localparam int unsigned OFS_DIR         = 'h400;
    localparam int unsigned OFS_PULL_UP     = 'h510;
    localparam int unsigned OFS_PULL_DN     = 'h514;
    // Lowest address bit of the per-access lane mask.
    localparam int unsigned MASK_LSB        = 2;

    // Class of the request seen on the bus in the current cycle.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_DATA,
        ACC_DIR,
        ACC_PULL_UP,
        ACC_PULL_DN,
        ACC_HOLE
    } acc_kind_e;

    // Source chosen for one pin in the current cycle.
    typedef enum logic [1:0] {
        PM_DRIVE,
        PM_PULL_HI,
        PM_PULL_LO,
        PM_FLOAT
    } pin_mode_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned LINES    = 8,
    parameter bit          EXT_PULL = 1'b1
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [LINES-1:0]  lane_mask_o
);

    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(DATA_WINDOW_END);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_PU    = ADDR_W'(OFS_PULL_UP);
    localparam logic [ADDR_W-1:0] A_PD    = ADDR_W'(OFS_PULL_DN);

    // The lane mask comes straight from the address bits above the byte offset.
    assign lane_mask_o = addr_i[MASK_LSB +: LINES];

    always_comb begin
        kind_o = ACC_HOLE;
        if (!valid_i) begin
            kind_o = ACC_IDLE;
        end else if (addr_i < WIN_END) begin
            kind_o = ACC_DATA;
        end else if (addr_i == A_DIR) begin
            kind_o = ACC_DIR;
        end else if (EXT_PULL && (addr_i == A_PU)) begin
            kind_o = ACC_PULL_UP;
        end else if (EXT_PULL && (addr_i == A_PD)) begin
            kind_o = ACC_PULL_DN;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    // One shift chain per line; the oldest stage feeds the data register.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int unsigned      LINES         = 8,
    parameter int unsigned      DATA_W        = 32,
    parameter bit               EXT_PULL      = 1'b1,
    parameter logic [LINES-1:0] PULL_UP_FIXED = {LINES{1'b1}},
    parameter logic [LINES-1:0] PULL_DN_FIXED = {LINES{1'b0}}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  acc_kind_e         kind_i,
    input  logic              write_i,
    input  logic [LINES-1:0]  lane_mask_i,
    input  logic [LINES-1:0]  wdata_i,
    input  logic [LINES-1:0]  sync_i,
    output logic [LINES-1:0]  data_o,
    output logic [LINES-1:0]  dir_o,
    output logic [LINES-1:0]  pull_up_o,
    output logic [LINES-1:0]  pull_dn_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned PAD_W = DATA_W - LINES;

    logic [LINES-1:0]  data_q, data_nxt, dir_q, wr_lanes;
    logic [DATA_W-1:0] rdata_q, rd_nxt;

    // Lanes a data store may touch: selected by the address and set as outputs.
    assign wr_lanes = (write_i && (kind_i == ACC_DATA)) ? (lane_mask_i & dir_q) : '0;

    // Output lanes keep or take the store; input lanes follow the synchronizer.
    assign data_nxt = (data_q & dir_q & ~wr_lanes)
                    | (wdata_i & wr_lanes)
                    | (sync_i & ~dir_q);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else begin
            data_q <= data_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dir_q <= '0;
        end else if (write_i && (kind_i == ACC_DIR)) begin
            dir_q <= wdata_i;
        end
    end

    // Pull masks: software registers or fixed parameters.
    if (EXT_PULL) begin : g_pull_regs
        logic [LINES-1:0] pu_q, pd_q;

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pu_q <= '0;
                pd_q <= '0;
            end else if (write_i) begin
                if (kind_i == ACC_PULL_UP) pu_q <= wdata_i;
                if (kind_i == ACC_PULL_DN) pd_q <= wdata_i;
            end
        end

        assign pull_up_o = pu_q;
        assign pull_dn_o = pd_q;
    end else begin : g_pull_fixed
        assign pull_up_o = PULL_UP_FIXED;
        assign pull_dn_o = PULL_DN_FIXED;
    end

    // Read return value for each access class.
    always_comb begin
        rd_nxt = '0;
        unique case (kind_i)
            ACC_IDLE:    rd_nxt = '0;
            ACC_DATA:    rd_nxt = {{PAD_W{1'b0}}, data_q & lane_mask_i};
            ACC_DIR:     rd_nxt = {{PAD_W{1'b0}}, dir_q};
            ACC_PULL_UP: rd_nxt = {{PAD_W{1'b0}}, pull_up_o};
            ACC_PULL_DN: rd_nxt = {{PAD_W{1'b0}}, pull_dn_o};
            ACC_HOLE:    rd_nxt = '0;
            default:     rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if ((kind_i != ACC_IDLE) && !write_i) begin
            rdata_q <= rd_nxt;
        end
    end

    assign data_o  = data_q;
    assign dir_o   = dir_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_port_pkg::*;
#(
    parameter int unsigned      LINES      = 8,
    parameter logic [LINES-1:0] RESET_PINS = {LINES{1'b1}}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] dir_i,
    input  logic [LINES-1:0] data_i,
    input  logic [LINES-1:0] pull_up_i,
    input  logic [LINES-1:0] pull_dn_i,
    output logic [LINES-1:0] pin_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        pin_mode_e mode;
        logic      pin_q, pin_nxt;

        // Mode priority: direction, then pull-up, then pull-down.
        always_comb begin
            if (dir_i[g])          mode = PM_DRIVE;
            else if (pull_up_i[g]) mode = PM_PULL_HI;
            else if (pull_dn_i[g]) mode = PM_PULL_LO;
            else                   mode = PM_FLOAT;
        end

        always_comb begin
            pin_nxt = pin_q;
            unique case (mode)
                PM_DRIVE:   pin_nxt = data_i[g];
                PM_PULL_HI: pin_nxt = 1'b1;
                PM_PULL_LO: pin_nxt = 1'b0;
                PM_FLOAT:   pin_nxt = pin_q;
                default:    pin_nxt = pin_q;
            endcase
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pin_q <= RESET_PINS[g];
            end else begin
                pin_q <= pin_nxt;
            end
        end

        assign pin_o[g] = pin_q;
    end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned      LINES         = 8,
    parameter int unsigned      ADDR_W        = 12,
    parameter int unsigned      DATA_W        = 32,
    parameter int unsigned      SYNC_STAGES   = 2,
    parameter bit               EXT_PULL      = 1'b1,
    parameter logic [LINES-1:0] PULL_UP_FIXED = {LINES{1'b1}},
    parameter logic [LINES-1:0] PULL_DN_FIXED = {LINES{1'b0}}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [LINES-1:0]  pin_i,
    output logic [LINES-1:0]  pin_o
);

    // At reset every line is an input, so each pin shows its pull-up bit.
    localparam logic [LINES-1:0] RESET_PINS = EXT_PULL ? '0 : PULL_UP_FIXED;

    acc_kind_e        acc_kind;
    logic [LINES-1:0] lane_mask;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] data_q, dir_q, pull_up, pull_dn;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:LINES];

    gpio_bus_decode #(
        .ADDR_W   (ADDR_W),
        .LINES    (LINES),
        .EXT_PULL (EXT_PULL)
    ) decode_i (
        .valid_i     (bus_valid_i),
        .addr_i      (bus_addr_i),
        .kind_o      (acc_kind),
        .lane_mask_o (lane_mask)
    );

    gpio_in_sync #(
        .LINES  (LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (sync_q)
    );

    gpio_reg_bank #(
        .LINES         (LINES),
        .DATA_W        (DATA_W),
        .EXT_PULL      (EXT_PULL),
        .PULL_UP_FIXED (PULL_UP_FIXED),
        .PULL_DN_FIXED (PULL_DN_FIXED)
    ) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .kind_i      (acc_kind),
        .write_i     (bus_write_i),
        .lane_mask_i (lane_mask),
        .wdata_i     (bus_wdata_i[LINES-1:0]),
        .sync_i      (sync_q),
        .data_o      (data_q),
        .dir_o       (dir_q),
        .pull_up_o   (pull_up),
        .pull_dn_o   (pull_dn),
        .rdata_o     (bus_rdata_o)
    );

    gpio_pin_resolve #(
        .LINES      (LINES),
        .RESET_PINS (RESET_PINS)
    ) resolve_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .dir_i     (dir_q),
        .data_i    (data_q),
        .pull_up_i (pull_up),
        .pull_dn_i (pull_dn),
        .pin_o     (pin_o)
    );

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned LINES  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [LINES-1:0]  wdata_lo_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [LINES-1:0]  pin_o,
    input logic [LINES-1:0]  data_q,
    input logic [LINES-1:0]  dir_q,
    input logic [LINES-1:0]  pull_up,
    input logic [LINES-1:0]  pull_dn,
    input logic [LINES-1:0]  sync_q
);

    logic             in_window, dir_store, data_load;
    logic [LINES-1:0] lanes, wr_lanes, pu_in, pd_in, fl_in;

    assign in_window = bus_addr_i < ADDR_W'(DATA_WINDOW_END);
    assign lanes     = bus_addr_i[MASK_LSB +: LINES];
    assign wr_lanes  = (bus_valid_i && bus_write_i && in_window) ? lanes : '0;
    assign data_load = bus_valid_i && !bus_write_i && in_window;
    assign dir_store = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(OFS_DIR));
    assign pu_in     = pull_up & ~dir_q;
    assign pd_in     = pull_dn & ~pull_up & ~dir_q;
    assign fl_in     = ~dir_q & ~pull_up & ~pull_dn;

    a_r2_read_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_load |=> (bus_rdata_o == {{(DATA_W-LINES){1'b0}}, $past(data_q & lanes)}));

    a_r3_dir_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dir_store |=> (dir_q == $past(wdata_lo_i)));

    a_r10_dir_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dir_store |=> $stable(dir_q));

    a_r4_write_lanes_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_lanes)) == '0));

    a_r5_input_from_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((data_q & ~$past(dir_q)) == ($past(sync_q) & ~$past(dir_q))));

    a_r6_output_follows_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pin_o & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    a_r7_pull_up_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pin_o & $past(pu_in)) == $past(pu_in)));

    a_r7_pull_dn_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pin_o & $past(pd_in)) == '0));

    a_r8_float_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((pin_o ^ $past(pin_o)) & $past(fl_in)) == '0));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .LINES  (LINES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .wdata_lo_i  (bus_wdata_i[LINES-1:0]),
    .bus_rdata_o (bus_rdata_o),
    .pin_o       (pin_o),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .pull_up     (pull_up),
    .pull_dn     (pull_dn),
    .sync_q      (sync_q)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rd_ext, rd_fx;
    logic [7:0]  pin_ext, pin_fx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model, built from the requirements.
    logic [7:0] m_data = '0, m_dir = '0, m_pu = '0, m_pd = '0, m_pin = '0;

    always #2.5 clk = ~clk;

    gpio_mask_port dut_i (
        .clk_i (clk), .rst_ni (rst_ni),
        .bus_valid_i (bus_valid), .bus_write_i (bus_write),
        .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
        .bus_rdata_o (rd_ext), .pin_i (pin_in), .pin_o (pin_ext)
    );

    gpio_mask_port #(.EXT_PULL (1'b0)) dut_fx_i (
        .clk_i (clk), .rst_ni (rst_ni),
        .bus_valid_i (bus_valid), .bus_write_i (bus_write),
        .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
        .bus_rdata_o (rd_fx), .pin_i (pin_in), .pin_o (pin_fx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fx_pins();
        return (m_data & m_dir) | ~m_dir;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
        m_data = (m_data & m_dir) | (pin_in & ~m_dir);
        m_pin  = (m_data & m_dir) | (m_pu & ~m_dir) | (m_pin & ~m_dir & ~m_pu & ~m_pd);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [7:0] lanes;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (a < 12'h400) begin
            lanes  = a[9:2] & m_dir;
            m_data = (m_data & ~lanes) | (d[7:0] & lanes);
        end else if (a == 12'h400) m_dir = d[7:0];
        else if (a == 12'h510) m_pu = d[7:0];
        else if (a == 12'h514) m_pd = d[7:0];
        settle();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] re, output logic [31:0] rf);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        re = rd_ext; rf = rd_fx;
    endtask

    task automatic chk_both(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] re, rf;
        rd(a, re, rf);
        chk({tag, " ext"}, re, exp);
        chk({tag, " fixed"}, rf, exp);
    endtask

    task automatic chk_pins(input string tag);
        chk({tag, " ext pins"}, {24'h0, pin_ext}, {24'h0, m_pin});
        chk({tag, " fixed pins"}, {24'h0, pin_fx}, {24'h0, fx_pins()});
    endtask

    task automatic t_reset();
        logic [31:0] re, rf;
        chk("R1 pins ext", {24'h0, pin_ext}, 32'h0);
        chk("R1 pins fixed", {24'h0, pin_fx}, 32'hFF);
        chk_both("R1 data", 12'h3FC, 32'h0);
        chk_both("R1 dir", 12'h400, 32'h0);
        rd(12'h510, re, rf);
        chk("R9 pull-up reset ext", re, 32'h0);
        chk("R9 pull-up fixed reads 0", rf, 32'h0);
    endtask

    task automatic t_dir_reg();
        wr(12'h400, 32'hFFFF_A5C3);
        chk_both("R3 dir low byte", 12'h400, 32'h0000_00C3);
        chk_pins("R6 after dir");
        wr(12'h400, 32'h0);
    endtask

    task automatic t_masked_write();
        wr(12'h400, 32'hFF);
        wr(12'h3FC, 32'h00);
        wr(12'h03C, 32'hFF);
        chk_both("R4 lanes 3:0", 12'h3FC, {24'h0, m_data});
        chk("R4 model", {24'h0, m_data}, 32'h0F);
        wr(12'h400, 32'hF0);
        wr(12'h3C0, 32'hAA);
        wr(12'h00C, 32'hFF);
        chk_both("R4 input lanes untouched", 12'h3FC, {24'h0, m_data});
        chk_pins("R6 outputs");
    endtask

    task automatic t_read_mask();
        wr(12'h400, 32'hFF);
        wr(12'h3FC, 32'hA5);
        chk_both("R2 mask 0x3C", 12'h0F0, 32'h24);
        chk_both("R2 mask 0", 12'h000, 32'h0);
        chk_both("R2 low addr bits", 12'h3FF, 32'hA5);
        chk_pins("R6 all outputs");
    endtask

    task automatic t_input_sample();
        logic [31:0] re, rf;
        logic [7:0]  old_v;
        wr(12'h400, 32'h0F);
        old_v  = m_data;
        pin_in = 8'hFF;
        rd(12'h3FC, re, rf);
        rd(12'h3FC, re, rf);
        rd(12'h3FC, re, rf);
        chk("R5 not yet after two stages", re, {24'h0, old_v});
        rd(12'h3FC, re, rf);
        chk("R5 input sampled, outputs ignore pin", re, {24'h0, (old_v & 8'h0F) | 8'hF0});
        settle();
        chk_both("R5 settled", 12'h3FC, {24'h0, m_data});
        pin_in = 8'h00;
        settle();
        chk_both("R5 low again", 12'h3FC, {24'h0, m_data});
    endtask

    task automatic t_pulls();
        logic [31:0] re, rf;
        wr(12'h400, 32'h0F);
        wr(12'h510, 32'hFFFF_FF30);
        wr(12'h514, 32'h0000_00C0);
        rd(12'h510, re, rf);
        chk("R9 pull-up ext", re, 32'h30);
        chk("R9 pull-up fixed", rf, 32'h0);
        rd(12'h514, re, rf);
        chk("R9 pull-dn ext", re, 32'hC0);
        chk("R9 pull-dn fixed", rf, 32'h0);
        chk_pins("R7 up and down");
        wr(12'h514, 32'hF0);
        chk_pins("R7 both set, up wins");
        chk("R7 ext bits 7:4", {24'h0, pin_ext & 8'hF0}, 32'h30);
    endtask

    task automatic t_float();
        wr(12'h510, 32'h0);
        wr(12'h514, 32'h0);
        wr(12'h400, 32'hFF);
        wr(12'h3FC, 32'h5A);
        chk_pins("R8 driven before");
        wr(12'h400, 32'h00);
        chk("R8 hold after release", {24'h0, pin_ext}, 32'h5A);
        pin_in = 8'hA5;
        settle();
        repeat (20) @(negedge clk);
        chk("R8 hold under input change", {24'h0, pin_ext}, 32'h5A);
        chk_pins("R8 model");
    endtask

    task automatic t_unmapped();
        logic [7:0] dir_b, data_b, pe_b, pf_b;
        wr(12'h400, 32'h3C);
        dir_b = m_dir; data_b = m_data; pe_b = pin_ext; pf_b = pin_fx;
        wr(12'h404, 32'hFF);
        wr(12'h401, 32'hFF);
        wr(12'hFFC, 32'hFF);
        chk_both("R10 hole 0x404", 12'h404, 32'h0);
        chk_both("R10 hole 0x401", 12'h401, 32'h0);
        chk_both("R10 hole 0xFFC", 12'hFFC, 32'h0);
        chk_both("R10 dir kept", 12'h400, {24'h0, dir_b});
        chk_both("R10 data kept", 12'h3FC, {24'h0, data_b});
        chk("R10 ext pins kept", {24'h0, pin_ext}, {24'h0, pe_b});
        chk("R10 fixed pins kept", {24'h0, pin_fx}, {24'h0, pf_b});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        m_pin  = 8'h00;
        @(negedge clk);
        t_reset();
        t_dir_reg();
        t_masked_write();
        t_read_mask();
        t_input_sample();
        t_pulls();
        t_float();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule